// File: doc/BRIEF.md
# Multiprocessor-Aware Asynchronous Serial Interface

This block is a full-duplex asynchronous serial port with a small register bus. It serialises bytes written by software onto a transmit line and assembles characters arriving on a receive line into a holding register. Level flags report the state of both directions. The transmitter and the receiver each have their own enable. A character is framed by a start bit and a stop bit. It carries 8 data bits, least significant first, and may carry one further bit: either an even or odd parity bit, or a multiprocessor bit that tags the character as a station ID (1) or as payload (0).

On a shared multi-drop line, a listening station arms an ID filter. While the filter is armed and the multiprocessor format is selected, the receiver quietly drops payload characters. When the next ID character arrives, hardware disarms the filter and the ID character is delivered normally. Software then reads the ID and decides whether to stay disarmed for the payload that follows or to re-arm the filter.

Timing comes from an external tick input that pulses once per sixteenth of a bit. Baud-rate generation lies outside the block.

Top module: `mpUart`

## Requirements
- R1: After reset, the control register (address 0) reads 0x00, the status register (address 2) reads 0x01, the rxFull pin is 0, the txEmpty pin is 1 and txd is 1. The control bits are: bit 0 transmit enable, bit 1 receive enable, bit 2 ID filter, bit 3 multiprocessor format, bit 4 parity on, bit 5 odd parity, bit 6 multiprocessor bit to send. The status bits are: bit 0 transmit empty, bit 1 receive full, bit 2 framing error, bit 3 parity error, bit 4 overrun.
- R2: While transmit enable is 0, transmit empty reads 1 at all times. An attempt to clear it has no effect, and txd stays high.
- R3: A frame is sent only when transmit enable is 1, a byte has been written to address 1, and transmit empty has then been cleared. Transmit empty returns to 1 once the byte is taken into the shifter. Each bit lasts 16 ticks. The frame is a 0 start bit, then 8 data bits LSB first, then the extra bit when present, then a 1 stop bit.
- R4: The extra transmit bit is the bit-6 control value when the multiprocessor format is on, in which case parity is ignored. Otherwise, with parity on, it is the XOR of the data bits XOR the odd-parity bit. With neither on, the frame has no extra bit.
- R5: A character is received only while receive enable is 1. Line activity with receive enable at 0 leaves every receive flag and the holding register unchanged.
- R6: The start bit is rechecked 8 ticks after the falling edge. If the line is high again, the event is a false start and no character results.
- R7: A completed character loads the holding register (address 3) and sets receive full. The framing error is set when the stop bit is 0. The parity error is set when parity is on and the received parity bit does not match the rule of R4.
- R8: When a character completes while receive full is 1, overrun is set and the holding register keeps its earlier byte.
- R9: Clearing receive enable leaves receive full, the error flags and the overrun flag unchanged.
- R10: With the ID filter and the multiprocessor format both on, a character whose multiprocessor bit is 0 is dropped. Receive full, both error flags and overrun stay unchanged, even when its stop bit is 0.
- R11: With the ID filter and the multiprocessor format both on, a character whose multiprocessor bit is 1 clears control bit 2 and is delivered as in R7.
- R12: With the multiprocessor format off, the ID filter has no effect. Characters are delivered and control bit 2 stays 1.
- R13: A write to the status register clears each of bits 0 to 4 whose written value is 0. A written 1 leaves the flag as it is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| baudTick | input | 1 | One-cycle pulse at 16 times the bit rate |
| busWr | input | 1 | Register write strobe |
| busAddr | input | 2 | Register address (0 control, 1 transmit data, 2 status, 3 receive data) |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data for busAddr, combinational |
| rxd | input | 1 | Serial receive line, idle high |
| txd | output | 1 | Serial transmit line, idle high |
| txEmpty | output | 1 | Transmit empty flag level |
| rxFull | output | 1 | Receive full flag level |

## Verification
The hardest case to reach from the ports is a character that arrives while the ID filter is armed and also carries a broken stop bit and a multiprocessor bit of 0. It has to vanish without a trace. The ID character that follows must then disarm the filter in the same cycle in which it is delivered. The bench gets there with a bit-level line driver that chooses the data, the extra bit and the stop value of each frame independently. Between frames the bench reads back the control and status registers. A short low pulse, shorter than half a bit, is used to exercise the false-start path. The receiver is then shown to accept a proper frame right after it.

// File: rtl/mpUartPkg.sv
package mpUartPkg;
  localparam int DATA_W  = 8;
  localparam int FRAME_W = DATA_W + 3;
  localparam int REG_W   = 8;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_TXD  = 2'd1;
  localparam logic [1:0] A_STAT = 2'd2;
  localparam logic [1:0] A_RXD  = 2'd3;

  typedef struct packed {
    logic txOn;
    logic rxOn;
    logic idFilter;
    logic mpFmt;
    logic parOn;
    logic parOdd;
    logic txMpBit;
  } cfg_t;

  // strobes from control to datapath
  typedef struct packed {
    logic              txStart;
    logic [DATA_W-1:0] txByte;
    logic              txExtra;
    logic              txLong;
  } ctrlStb_t;

  // one completed character from the receiver
  typedef struct packed {
    logic              done;
    logic [DATA_W-1:0] data;
    logic              mpBit;
    logic              frmErr;
    logic              parErr;
  } rxRes_t;

  typedef struct packed {
    logic txEmpty;
    logic rxFull;
    logic frmErr;
    logic parErr;
    logic ovr;
  } stat_t;

  function automatic logic parBit(input logic [DATA_W-1:0] d, input logic odd);
    return (^d) ^ odd;
  endfunction
endpackage

// File: rtl/mpUartCtrl.sv
module mpUartCtrl
  import mpUartPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             busWr,
  input  logic [1:0]       busAddr,
  input  logic [REG_W-1:0] busWdata,
  output logic [REG_W-1:0] busRdata,
  input  rxRes_t           res,
  input  logic             txBusy,
  output cfg_t             cfg,
  output ctrlStb_t         stb,
  output stat_t            stat,
  output logic [DATA_W-1:0] rxHeld
);
  logic [DATA_W-1:0] txBuf;
  logic wrCtrl, wrTx, wrStat;
  logic rxAccept, filtering, dropIt, take;

  assign wrCtrl = busWr && (busAddr == A_CTRL);
  assign wrTx   = busWr && (busAddr == A_TXD);
  assign wrStat = busWr && (busAddr == A_STAT);

  assign rxAccept  = res.done && cfg.rxOn;
  assign filtering = cfg.idFilter && cfg.mpFmt;
  assign dropIt    = filtering && !res.mpBit;
  assign take      = rxAccept && !dropIt;

  // control register; the ID filter is disarmed by an ID character
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfg <= '0;
    end else begin
      if (wrCtrl) begin
        cfg.txOn     <= busWdata[0];
        cfg.rxOn     <= busWdata[1];
        cfg.idFilter <= busWdata[2];
        cfg.mpFmt    <= busWdata[3];
        cfg.parOn    <= busWdata[4];
        cfg.parOdd   <= busWdata[5];
        cfg.txMpBit  <= busWdata[6];
      end
      if (rxAccept && filtering && res.mpBit) cfg.idFilter <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) txBuf <= '0;
    else if (wrTx) txBuf <= busWdata[DATA_W-1:0];
  end

  always_comb begin
    stb.txStart = cfg.txOn && !stat.txEmpty && !txBusy;
    stb.txByte  = txBuf;
    stb.txLong  = cfg.mpFmt || cfg.parOn;
    stb.txExtra = cfg.mpFmt ? cfg.txMpBit : parBit(txBuf, cfg.parOdd);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stat   <= '{txEmpty: 1'b1, default: 1'b0};
      rxHeld <= '0;
    end else begin
      if (!cfg.txOn)                      stat.txEmpty <= 1'b1;
      else if (stb.txStart)               stat.txEmpty <= 1'b1;
      else if (wrStat && !busWdata[0])    stat.txEmpty <= 1'b0;

      if (wrStat) begin
        if (!busWdata[1]) stat.rxFull <= 1'b0;
        if (!busWdata[2]) stat.frmErr <= 1'b0;
        if (!busWdata[3]) stat.parErr <= 1'b0;
        if (!busWdata[4]) stat.ovr    <= 1'b0;
      end

      if (take) begin
        if (stat.rxFull) begin
          stat.ovr <= 1'b1;
        end else begin
          stat.rxFull <= 1'b1;
          rxHeld      <= res.data;
          if (res.frmErr) stat.frmErr <= 1'b1;
          if (res.parErr) stat.parErr <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    busRdata = '0;
    case (busAddr)
      A_CTRL: busRdata = {1'b0, cfg.txMpBit, cfg.parOdd, cfg.parOn,
                          cfg.mpFmt, cfg.idFilter, cfg.rxOn, cfg.txOn};
      A_TXD:  busRdata = txBuf;
      A_STAT: busRdata = {3'b000, stat.ovr, stat.parErr, stat.frmErr,
                          stat.rxFull, stat.txEmpty};
      default: busRdata = rxHeld;
    endcase
  end
endmodule

// File: rtl/mpUartDatapath.sv
module mpUartDatapath
  import mpUartPkg::*;
#(
  parameter int OVS = 16
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     baudTick,
  input  logic     rxd,
  input  cfg_t     cfg,
  input  ctrlStb_t stb,
  output logic     txd,
  output logic     txBusy,
  output rxRes_t   res
);
  localparam int CW = $clog2(OVS);
  localparam int IW = $clog2(FRAME_W + 1);
  localparam logic [CW-1:0] MID  = CW'(OVS / 2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OVS - 1);
  localparam logic [IW-1:0] LEN_LONG  = IW'(FRAME_W - 1);
  localparam logic [IW-1:0] LEN_SHORT = IW'(FRAME_W - 2);

  // ---------------- transmitter ----------------
  logic                txAct;
  logic [CW-1:0]       txCnt;
  logic [IW-1:0]       txLeft;
  logic [FRAME_W-1:0]  txFrm;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txAct  <= 1'b0;
      txCnt  <= '0;
      txLeft <= '0;
      txFrm  <= '1;
    end else if (!txAct) begin
      if (stb.txStart) begin
        txAct  <= 1'b1;
        txCnt  <= '0;
        txFrm  <= {1'b1, (stb.txLong ? stb.txExtra : 1'b1), stb.txByte, 1'b0};
        txLeft <= stb.txLong ? LEN_LONG : LEN_SHORT;
      end
    end else if (baudTick) begin
      txCnt <= (txCnt == LAST) ? '0 : txCnt + 1'b1;
      if (txCnt == LAST) begin
        if (txLeft == '0) begin
          txAct <= 1'b0;
        end else begin
          txFrm  <= {1'b1, txFrm[FRAME_W-1:1]};
          txLeft <= txLeft - 1'b1;
        end
      end
    end
  end

  assign txd    = txAct ? txFrm[0] : 1'b1;
  assign txBusy = txAct;

  // ---------------- receiver ----------------
  logic              rxMeta, rxSync;
  logic              rxAct;
  logic [CW-1:0]     rxCnt;
  logic [IW-1:0]     rxIdx;
  logic [IW-1:0]     rxStop;
  logic [DATA_W-1:0] rxSh;
  logic              rxExtra;

  assign rxStop = (cfg.mpFmt || cfg.parOn) ? LEN_LONG : LEN_SHORT;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxMeta  <= 1'b1;
      rxSync  <= 1'b1;
      rxAct   <= 1'b0;
      rxCnt   <= '0;
      rxIdx   <= '0;
      rxSh    <= '0;
      rxExtra <= 1'b0;
      res     <= '0;
    end else begin
      res.done <= 1'b0;
      rxMeta   <= rxd;
      rxSync   <= rxMeta;
      if (!cfg.rxOn) begin
        rxAct <= 1'b0;
      end else if (baudTick) begin
        if (!rxAct) begin
          if (!rxSync) begin
            rxAct <= 1'b1;
            rxCnt <= '0;
            rxIdx <= '0;
          end
        end else begin
          rxCnt <= (rxCnt == LAST) ? '0 : rxCnt + 1'b1;
          if (rxCnt == LAST) rxIdx <= rxIdx + 1'b1;
          if (rxCnt == MID) begin
            if (rxIdx == '0) begin
              if (rxSync) rxAct <= 1'b0;   // false start
            end else if (rxIdx <= IW'(DATA_W)) begin
              rxSh <= {rxSync, rxSh[DATA_W-1:1]};
            end else if (rxIdx == rxStop) begin
              rxAct      <= 1'b0;
              res.done   <= 1'b1;
              res.data   <= rxSh;
              res.mpBit  <= cfg.mpFmt && rxExtra;
              res.frmErr <= !rxSync;
              res.parErr <= cfg.parOn && !cfg.mpFmt &&
                            (rxExtra != parBit(rxSh, cfg.parOdd));
            end else begin
              rxExtra <= rxSync;
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/mpUart.sv
module mpUart
  import mpUartPkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       baudTick,
  input  logic       busWr,
  input  logic [1:0] busAddr,
  input  logic [7:0] busWdata,
  output logic [7:0] busRdata,
  input  logic       rxd,
  output logic       txd,
  output logic       txEmpty,
  output logic       rxFull
);
  cfg_t              cfg;
  ctrlStb_t          stb;
  stat_t             stat;
  rxRes_t            res;
  logic              txBusy;
  logic [DATA_W-1:0] rxHeld;

  mpUartCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .res(res), .txBusy(txBusy),
    .cfg(cfg), .stb(stb), .stat(stat), .rxHeld(rxHeld)
  );

  mpUartDatapath #(.OVS(OVS)) u_dp (
    .clk(clk), .rstN(rstN), .baudTick(baudTick), .rxd(rxd), .cfg(cfg),
    .stb(stb), .txd(txd), .txBusy(txBusy), .res(res)
  );

  assign txEmpty = stat.txEmpty;
  assign rxFull  = stat.rxFull;
endmodule

// File: rtl/mpUartChk.sv
module mpUartChk
  import mpUartPkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              busWr,
  input logic [1:0]        busAddr,
  input cfg_t              cfg,
  input stat_t             stat,
  input logic [DATA_W-1:0] rxHeld,
  input rxRes_t            res,
  input logic              txBusy
);
  logic wrStat;
  assign wrStat = busWr && (busAddr == 2'd2);

  AST_TXE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !cfg.txOn |=> stat.txEmpty); // R2

  AST_TX_START_ARMED: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txBusy) |-> ($past(cfg.txOn) && !$past(stat.txEmpty) && stat.txEmpty)); // R3

  AST_HELD_WHILE_FULL: assert property (@(posedge clk) disable iff (!rstN)
    (stat.rxFull && !wrStat) |=> $stable(rxHeld)); // R8

  AST_FLAGS_KEEP_RXOFF: assert property (@(posedge clk) disable iff (!rstN)
    (!cfg.rxOn && !wrStat) |=> ($stable(stat.rxFull) && $stable(stat.frmErr) &&
                                $stable(stat.parErr) && $stable(stat.ovr))); // R9

  AST_FILTER_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.idFilter && cfg.mpFmt && cfg.rxOn && res.done && !res.mpBit && !wrStat)
    |=> ($stable(stat.rxFull) && $stable(stat.frmErr) && $stable(stat.parErr) &&
         $stable(stat.ovr) && $stable(rxHeld))); // R10

  AST_ID_DISARMS: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.idFilter && cfg.mpFmt && cfg.rxOn && res.done && res.mpBit)
    |=> (!cfg.idFilter && stat.rxFull)); // R11
endmodule

bind mpUart mpUartChk u_chk (
  .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr), .cfg(cfg),
  .stat(stat), .rxHeld(rxHeld), .res(res), .txBusy(txBusy)
);

// File: tb/sim_mpUart.sv
`timescale 1ns/1ps
module sim_mpUart;
  localparam int TDIV   = 4;
  localparam int BITCLK = 16 * TDIV;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       baudTick = 1'b0;
  logic       busWr = 1'b0;
  logic [1:0] busAddr = 2'd0;
  logic [7:0] busWdata = 8'd0;
  logic [7:0] busRdata;
  logic       rxd = 1'b1;
  logic       txd;
  logic       txEmpty;
  logic       rxFull;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [10:0] expQ[$];
  int          lenQ[$];

  mpUart u0 (
    .clk(clk), .rstN(rstN), .baudTick(baudTick), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .rxd(rxd), .txd(txd), .txEmpty(txEmpty), .rxFull(rxFull)
  );

  always #5 clk = ~clk;

  initial begin
    forever begin
      repeat (TDIV - 1) @(negedge clk);
      baudTick = 1'b1;
      @(negedge clk);
      baudTick = 1'b0;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdata;
  endtask

  // driver: queue the expected line image, then hand the byte to the block
  task automatic sendTx(input logic [7:0] d, input bit longFrm, input logic extra);
    logic [7:0] s;
    s = 8'h00;
    while (s[0] !== 1'b1) rd(2'd2, s);
    expQ.push_back(longFrm ? {1'b1, extra, d, 1'b0} : {1'b1, 1'b1, d, 1'b0});
    lenQ.push_back(longFrm ? 11 : 10);
    wr(2'd1, d);
    wr(2'd2, 8'hFE);
  endtask

  task automatic waitTxDone();
    while (expQ.size() != 0) @(negedge clk);
    repeat (BITCLK) @(negedge clk);
  endtask

  task automatic rxFrame(input logic [7:0] d, input bit hasExtra, input logic extra,
                         input logic stopV);
    @(negedge clk);
    rxd = 1'b0;
    repeat (BITCLK) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = d[i];
      repeat (BITCLK) @(negedge clk);
    end
    if (hasExtra) begin
      rxd = extra;
      repeat (BITCLK) @(negedge clk);
    end
    rxd = stopV;
    repeat (BITCLK) @(negedge clk);
    rxd = 1'b1;
    repeat (BITCLK) @(negedge clk);
  endtask

  // monitor: decode the transmit line and compare against the queue
  initial begin
    logic [10:0] got;
    int len;
    wait (rstN);
    forever begin
      @(negedge txd);
      len = (lenQ.size() != 0) ? lenQ[0] : 10;
      got = '1;
      repeat (BITCLK / 2) @(negedge clk);
      got[0] = txd;
      for (int i = 1; i < len; i++) begin
        repeat (BITCLK) @(negedge clk);
        got[i] = txd;
      end
      checks++;
      if (expQ.size() == 0) begin
        errors++;
        $display("FAIL R2/R3 unexpected frame actual=%h expected=none", got);
      end else begin
        if (got !== expQ[0]) begin
          errors++;
          $display("FAIL R3/R4 tx frame actual=%h expected=%h", got, expQ[0]);
        end
        void'(expQ.pop_front());
        void'(lenQ.pop_front());
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(2'd0, v); chk("R1 ctrl", v, 8'h00);
    rd(2'd2, v); chk("R1 status", v, 8'h01);
    chk("R1 pins", {txEmpty, rxFull, txd}, 3'b101);

    // R2 transmitter disabled
    wr(2'd1, 8'h5A);
    wr(2'd2, 8'hFE);
    rd(2'd2, v); chk("R2 empty held", v[0], 1'b1);
    repeat (12 * BITCLK) @(negedge clk);
    chk("R2 line idle", txd, 1'b1);

    // R3 plain frames, back to back
    wr(2'd0, 8'h01);
    sendTx(8'hA5, 0, 1'b0);
    repeat (4) @(negedge clk);
    rd(2'd2, v); chk("R3 empty after load", v[0], 1'b1);
    sendTx(8'h3C, 0, 1'b0);
    waitTxDone();
    // R4 parity even/odd, then mp bit with parity ignored
    wr(2'd0, 8'h11); sendTx(8'h07, 1, 1'b1); waitTxDone();
    wr(2'd0, 8'h31); sendTx(8'h07, 1, 1'b0); waitTxDone();
    wr(2'd0, 8'h59); sendTx(8'hC3, 1, 1'b1); waitTxDone();
    wr(2'd0, 8'h19); sendTx(8'h81, 1, 1'b0); waitTxDone();
    chk("R3 all frames seen", expQ.size(), 0);

    // R5 receiver off
    wr(2'd0, 8'h00);
    rxFrame(8'h33, 0, 1'b0, 1'b1);
    rd(2'd2, v); chk("R5 no receive when off", v, 8'h01);
    // R7 normal receive
    wr(2'd0, 8'h02);
    rxFrame(8'h81, 0, 1'b0, 1'b1);
    rd(2'd2, v); chk("R7 full set", v, 8'h03);
    rd(2'd3, v); chk("R7 data", v, 8'h81);
    chk("R7 pin", rxFull, 1'b1);
    // R13 write 1 keeps, write 0 clears
    wr(2'd2, 8'hFF);
    rd(2'd2, v); chk("R13 ones keep", v, 8'h03);
    // R8 overrun
    rxFrame(8'h42, 0, 1'b0, 1'b1);
    rd(2'd2, v); chk("R8 overrun flag", v, 8'h13);
    rd(2'd3, v); chk("R8 data kept", v, 8'h81);
    // R9 receiver off keeps flags
    wr(2'd0, 8'h00);
    rxFrame(8'h24, 0, 1'b0, 1'b1);
    rd(2'd2, v); chk("R9 flags kept", v, 8'h13);
    wr(2'd2, 8'hE1);
    rd(2'd2, v); chk("R13 zeros clear", v, 8'h01);

    // R7 framing and parity errors
    wr(2'd0, 8'h02);
    rxFrame(8'h55, 0, 1'b0, 1'b0);
    rd(2'd2, v); chk("R7 framing error", v, 8'h07);
    wr(2'd2, 8'hE1);
    wr(2'd0, 8'h12);
    rxFrame(8'h07, 1, 1'b0, 1'b1);
    rd(2'd2, v); chk("R7 parity error", v, 8'h0B);
    wr(2'd2, 8'hE1);
    rxFrame(8'h07, 1, 1'b1, 1'b1);
    rd(2'd2, v); chk("R7 parity good", v, 8'h03);
    wr(2'd2, 8'hE1);

    // R6 false start then a real frame
    wr(2'd0, 8'h02);
    @(negedge clk); rxd = 1'b0;
    repeat (BITCLK / 4) @(negedge clk);
    rxd = 1'b1;
    repeat (2 * BITCLK) @(negedge clk);
    rd(2'd2, v); chk("R6 false start ignored", v, 8'h01);
    rxFrame(8'h96, 0, 1'b0, 1'b1);
    rd(2'd3, v); chk("R6 recovers", v, 8'h96);
    wr(2'd2, 8'hE1);

    // R10 filter drops payload, even with a bad stop bit
    wr(2'd0, 8'h0E);
    rxFrame(8'h11, 1, 1'b0, 1'b1);
    rxFrame(8'h12, 1, 1'b0, 1'b0);
    rd(2'd2, v); chk("R10 no flags", v, 8'h01);
    rd(2'd3, v); chk("R10 data untouched", v, 8'h96);
    rd(2'd0, v); chk("R10 filter still armed", v, 8'h0E);
    // R11 ID character disarms and is delivered
    rxFrame(8'h22, 1, 1'b1, 1'b1);
    rd(2'd0, v); chk("R11 filter cleared", v, 8'h0A);
    rd(2'd2, v); chk("R11 delivered", v, 8'h03);
    rd(2'd3, v); chk("R11 data", v, 8'h22);
    wr(2'd2, 8'hE1);
    rxFrame(8'h44, 1, 1'b0, 1'b1);
    rd(2'd3, v); chk("R11 payload after disarm", v, 8'h44);
    wr(2'd2, 8'hE1);

    // R12 filter ignored outside multiprocessor format
    wr(2'd0, 8'h06);
    rxFrame(8'h5C, 0, 1'b0, 1'b1);
    rd(2'd3, v); chk("R12 delivered", v, 8'h5C);
    rd(2'd0, v); chk("R12 filter bit kept", v, 8'h06);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule